// File: doc/BRIEF.md
# Calendar Alarm Comparator with Repeat Masking

This block checks whether the current calendar time has reached a programmed alarm time. On every once-per-second update strobe it compares five BCD fields (seconds, minutes, hours, day of month and month) against the matching alarm fields. A five-bit repeat code can drop fields from that comparison. The codes form a graded set that makes the alarm fire once per second, minute, hour, day, month or year. Any other code fires on every update, so a wrong setting is noticed quickly.

A hit sets a sticky alarm flag. It also drives an active-low interrupt when the interrupt enable allows it. While the system runs on backup power, a second enable must also be set. Clearing takes two reads of the flags register: the first read releases the interrupt and the next read clears the flag. Four states carry this: `S_QUIET` (flag clear, interrupt released), `S_IRQ` (flag set, interrupt driven), `S_FLAG` (flag set, interrupt released) and `S_SPARE` (an unused encoding that returns to `S_QUIET`).

The transitions are named as follows:
- **arm**: a hit while enabled moves any state to `S_IRQ`.
- **latch**: a disabled hit moves `S_QUIET` to `S_FLAG`.
- **hold**: a disabled hit leaves `S_IRQ` or `S_FLAG` where it is.
- **ack**: a read in `S_IRQ` moves to `S_FLAG`.
- **drop**: a read in `S_FLAG` moves to `S_QUIET`.

Top module: `alarm_repeat_match`

## Requirements
- R1: The time and alarm buses each pack five 8-bit BCD fields. Field 0 (bits 7:0) is seconds, field 1 is minutes, field 2 is hours, field 3 is day of month and field 4 (bits 39:32) is month. Repeat bit i drops field i from the comparison when set, and a compared field must be equal in all eight bits.
- R2: The repeat codes 5'b11111, 5'b11110, 5'b11100, 5'b11000, 5'b10000 and 5'b00000 fire once per second, minute, hour, day, month and year respectively.
- R3: Any repeat code outside the R2 list drops every field, so each update strobe is a hit.
- R4: Comparison happens only in a cycle with `upd_tick` high. Equal fields without the strobe change nothing.
- R5: A hit sets `alarm_flag` on the next clock edge.
- R6: On main power, a hit drives `irq_n` low on the next edge only if `irq_en` is high. With `irq_en` low, the flag alone is set.
- R7: A `flags_rd` pulse while `irq_n` is low releases `irq_n` and leaves `alarm_flag` set.
- R8: A `flags_rd` pulse while `irq_n` is high clears `alarm_flag`.
- R9: With `on_backup` high, a hit drives `irq_n` low only when both `irq_en` and `backup_en` are high.
- R10: After reset, `alarm_flag` is low and `irq_n` is high.
- R11: A hit and a `flags_rd` pulse in the same cycle act as a hit. The read is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| upd_tick | input | 1 | Once-per-second time update strobe |
| cur_time | input | 40 | Current BCD time fields, packed as in R1 |
| alm_time | input | 40 | Alarm BCD fields, packed as in R1 |
| rpt | input | 5 | Repeat bits; bit i drops field i |
| irq_en | input | 1 | Alarm interrupt enable |
| backup_en | input | 1 | Interrupt enable while on backup power |
| on_backup | input | 1 | High while running on backup power |
| flags_rd | input | 1 | One-cycle strobe for a flags-register read |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
Both outputs come straight from the state register. A hit or a read presented in one cycle therefore shows on `alarm_flag` and `irq_n` after exactly one rising edge, and no result is due any later. The bench applies each stimulus at a falling edge and compares both outputs at the next falling edge, half a cycle after the edge that acts on the stimulus. Its reference model advances once per stimulus cycle with the same one-edge latency, so directed sequences and random traffic are checked at the same points.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;

    // Flag/interrupt clearing sequence states
    typedef enum logic [1:0] {
        S_QUIET = 2'b00,  // flag clear, interrupt released
        S_IRQ   = 2'b01,  // flag set, interrupt driven
        S_FLAG  = 2'b10,  // flag set, interrupt already acknowledged
        S_SPARE = 2'b11   // unused encoding, recovers to S_QUIET
    } alm_state_t;

endpackage

// File: rtl/alm_repeat_decode.sv
module alm_repeat_decode #(
    parameter int NUM_FIELDS = 5
) (
    input  logic [NUM_FIELDS-1:0] rpt,
    output logic [NUM_FIELDS-1:0] cmp_en
);

    localparam logic [NUM_FIELDS-1:0] ALL_ONES = {NUM_FIELDS{1'b1}};

    logic code_ok;

    // Legal codes are a run of ones anchored at the top bit (R2);
    // anything else compares nothing and fires every update (R3).
    always_comb begin
        code_ok = 1'b0;
        for (int k = 0; k <= NUM_FIELDS; k++) begin
            if (rpt == (ALL_ONES << k)) begin
                code_ok = 1'b1;
            end
        end
        cmp_en = code_ok ? ~rpt : '0;
    end

endmodule

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
    parameter int NUM_FIELDS = 5,
    parameter int FIELD_W    = 8
) (
    input  logic [NUM_FIELDS*FIELD_W-1:0] cur_time,
    input  logic [NUM_FIELDS*FIELD_W-1:0] alm_time,
    input  logic [NUM_FIELDS-1:0]         cmp_en,
    output logic                          all_match
);

    logic [NUM_FIELDS-1:0] field_ok;

    // One equality slice per field; a masked field always agrees (R1)
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
        assign field_ok[i] = !cmp_en[i] ||
            (cur_time[i*FIELD_W +: FIELD_W] == alm_time[i*FIELD_W +: FIELD_W]);
    end

    assign all_match = &field_ok;

endmodule

// File: rtl/alm_flag_fsm.sv
module alm_flag_fsm
    import alarm_match_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic irq_ok,
    input  logic flags_rd,
    output logic alarm_flag,
    output logic irq_n
);

    alm_state_t state, state_nx;

    // Next-state logic: a hit outranks a read (R11)
    always_comb begin
        state_nx = state;
        unique case (state)
            S_QUIET: begin
                if (hit) state_nx = irq_ok ? S_IRQ : S_FLAG;   // arm / latch
            end
            S_IRQ: begin
                if (hit)           state_nx = S_IRQ;           // arm / hold
                else if (flags_rd) state_nx = S_FLAG;          // ack (R7)
            end
            S_FLAG: begin
                if (hit)           state_nx = irq_ok ? S_IRQ : S_FLAG;
                else if (flags_rd) state_nx = S_QUIET;         // drop (R8)
            end
            S_SPARE: state_nx = S_QUIET;
            default: state_nx = S_QUIET;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_QUIET;
        else        state <= state_nx;
    end

    // Outputs decoded from state alone
    always_comb begin
        alarm_flag = 1'b0;
        irq_n      = 1'b1;
        unique case (state)
            S_QUIET: begin alarm_flag = 1'b0; irq_n = 1'b1; end
            S_IRQ:   begin alarm_flag = 1'b1; irq_n = 1'b0; end
            S_FLAG:  begin alarm_flag = 1'b1; irq_n = 1'b1; end
            S_SPARE: begin alarm_flag = 1'b0; irq_n = 1'b1; end
            default: begin alarm_flag = 1'b0; irq_n = 1'b1; end
        endcase
    end

    p_hit_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> alarm_flag);

    p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !irq_ok && irq_n) |=> irq_n);

    p_first_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && flags_rd && !irq_n) |=> (irq_n && alarm_flag));

    p_second_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && flags_rd && irq_n) |=> !alarm_flag);

    p_irq_implies_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> alarm_flag);

endmodule

// File: rtl/alarm_repeat_match.sv
module alarm_repeat_match #(
    parameter int NUM_FIELDS = 5,
    parameter int FIELD_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          upd_tick,
    input  logic [NUM_FIELDS*FIELD_W-1:0] cur_time,
    input  logic [NUM_FIELDS*FIELD_W-1:0] alm_time,
    input  logic [NUM_FIELDS-1:0]         rpt,
    input  logic                          irq_en,
    input  logic                          backup_en,
    input  logic                          on_backup,
    input  logic                          flags_rd,
    output logic                          alarm_flag,
    output logic                          irq_n
);

    logic [NUM_FIELDS-1:0] cmp_en;
    logic                  all_match;
    logic                  hit;
    logic                  irq_ok;

    alm_repeat_decode #(.NUM_FIELDS(NUM_FIELDS)) u_dec (
        .rpt    (rpt),
        .cmp_en (cmp_en)
    );

    alm_field_cmp #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_cmp (
        .cur_time  (cur_time),
        .alm_time  (alm_time),
        .cmp_en    (cmp_en),
        .all_match (all_match)
    );

    // Only the update strobe samples the comparison (R4)
    assign hit    = upd_tick && all_match;
    // Backup power needs the extra enable (R9)
    assign irq_ok = irq_en && (!on_backup || backup_en);

    alm_flag_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .irq_ok     (irq_ok),
        .flags_rd   (flags_rd),
        .alarm_flag (alarm_flag),
        .irq_n      (irq_n)
    );

    p_no_tick_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_tick && !alarm_flag) |=> !alarm_flag);

    p_backup_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (on_backup && !backup_en && irq_n) |=> irq_n);

    p_every_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_tick && cmp_en == '0) |=> alarm_flag);

endmodule

// File: tb/sim_alarm_repeat_match.sv
`timescale 1ns/1ps
module sim_alarm_repeat_match;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_tick = 1'b0;
    logic [39:0] cur_time = '0;
    logic [39:0] alm_time = '0;
    logic [4:0]  rpt = '0;
    logic        irq_en = 1'b0;
    logic        backup_en = 1'b0;
    logic        on_backup = 1'b0;
    logic        flags_rd = 1'b0;
    logic        alarm_flag;
    logic        irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit exp_flag = 1'b0;
    bit exp_irq  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    alarm_repeat_match u0 (
        .clk(clk), .rst_n(rst_n), .upd_tick(upd_tick),
        .cur_time(cur_time), .alm_time(alm_time), .rpt(rpt),
        .irq_en(irq_en), .backup_en(backup_en), .on_backup(on_backup),
        .flags_rd(flags_rd), .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    // Field compare mask from the repeat code (R1, R2, R3)
    function automatic logic [4:0] exp_mask(input logic [4:0] code);
        case (code)
            5'b11111, 5'b11110, 5'b11100, 5'b11000, 5'b10000, 5'b00000:
                return ~code;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic bit exp_match(input logic [39:0] c, input logic [39:0] a,
                                     input logic [4:0] code);
        logic [4:0] m;
        m = exp_mask(code);
        for (int i = 0; i < 5; i++) begin
            if (m[i] && (c[i*8 +: 8] != a[i*8 +: 8])) return 1'b0;
        end
        return 1'b1;
    endfunction

    // Apply one cycle of stimulus, advance the model, check one edge later
    task automatic cyc(input bit tk, input bit rd, input string tag);
        bit hit;
        bit ok;
        upd_tick = tk;
        flags_rd = rd;
        hit = tk && exp_match(cur_time, alm_time, rpt);
        ok  = irq_en && (!on_backup || backup_en);
        if (hit) begin
            exp_flag = 1'b1;
            if (ok) exp_irq = 1'b1;
        end else if (rd) begin
            if (exp_irq) exp_irq = 1'b0;
            else         exp_flag = 1'b0;
        end
        @(negedge clk);
        upd_tick = 1'b0;
        flags_rd = 1'b0;
        n_checks++;
        if (alarm_flag !== exp_flag || irq_n !== !exp_irq) begin
            n_fail++;
            $display("FAIL %s: flag=%b irq_n=%b expected flag=%b irq_n=%b",
                     tag, alarm_flag, irq_n, exp_flag, !exp_irq);
        end
    endtask

    function automatic logic [7:0] rnd_bcd();
        return {4'($urandom_range(0, 5)), 4'($urandom_range(0, 9))};
    endfunction

    initial begin
        #(200000 * 20);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        n_checks++;
        if (alarm_flag !== 1'b0 || irq_n !== 1'b1) begin
            n_fail++;
            $display("FAIL R10: flag=%b irq_n=%b expected flag=0 irq_n=1", alarm_flag, irq_n);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // Year mode, all fields equal except month
        cur_time = 40'h12_31_23_59_58;
        alm_time = 40'h11_31_23_59_58;
        rpt = 5'b00000;
        cyc(1, 0, "R1 month differs");
        alm_time = cur_time;
        cyc(0, 0, "R4 no tick");
        cyc(1, 0, "R2 year match, R6 irq_en low");
        cyc(1, 0, "R5 flag stays");
        cyc(0, 1, "R8 read clears flag");
        irq_en = 1'b1;
        cyc(1, 0, "R6 irq asserted");
        cyc(0, 1, "R7 first read");
        cyc(0, 1, "R8 second read");

        // Minute mode: seconds compared only
        rpt = 5'b11110;
        alm_time = 40'h01_01_00_00_57;
        cyc(1, 0, "R2 minute mode sec differs");
        alm_time = 40'h01_01_00_00_58;
        cyc(1, 0, "R2 minute mode sec equal");
        cyc(1, 1, "R11 hit beats read");
        cyc(0, 1, "R7 ack");
        cyc(0, 1, "R8 drop");

        // Illegal code fires on every tick
        rpt = 5'b10101;
        alm_time = 40'h09_09_09_09_09;
        cyc(1, 0, "R3 bad code");
        cyc(0, 1, "R7");
        cyc(0, 1, "R8");

        // Backup power gating
        on_backup = 1'b1;
        backup_en = 1'b0;
        cyc(1, 0, "R9 backup without enable");
        cyc(0, 1, "R8");
        backup_en = 1'b1;
        cyc(1, 0, "R9 backup with both enables");
        cyc(0, 1, "R7");
        cyc(0, 1, "R8");
        on_backup = 1'b0;

        // Constrained random traffic
        for (int n = 0; n < 400; n++) begin
            logic [4:0] codes [6];
            codes = '{5'b11111, 5'b11110, 5'b11100, 5'b11000, 5'b10000, 5'b00000};
            for (int f = 0; f < 5; f++) cur_time[f*8 +: 8] = rnd_bcd();
            alm_time = cur_time;
            for (int f = 0; f < 5; f++)
                if ($urandom_range(0, 3) == 0) alm_time[f*8 +: 8] = rnd_bcd();
            if ($urandom_range(0, 4) == 0) rpt = 5'($urandom);
            else rpt = codes[$urandom_range(0, 5)];
            irq_en    = 1'($urandom);
            backup_en = 1'($urandom);
            on_backup = ($urandom_range(0, 3) == 0);
            cyc(1'($urandom), ($urandom_range(0, 2) == 0), "R1 random");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule